// File: doc/BRIEF.md
# Streaming 2D Convolution Accumulator

This block computes a valid-mode two-dimensional convolution of one image plane with a small square kernel of K by K signed coefficients. It then adds the result, position by position, to a partial-sum plane that arrives on a second stream. Because the output can feed the partial-sum input of a later pass, the contributions of several input planes can be summed over successive runs.

Image pixels arrive one per clock in row-major order on a valid/ready stream. K-1 line buffers and a K by K window register present every tap of the current window at once. All K*K products are formed in parallel and summed in a 48-bit accumulator. The final stage takes one partial-sum value and adds it to the scaled convolution result. That stage also saturates the value and presents it on the output stream. Once the pipeline has filled, the block delivers one result per clock. A stall on any stream freezes the whole pipeline.

Software loads the coefficients through a write port while the block is idle. It then pulses a start input, and reads a done flag once the last result has been taken.

Top module: `conv_plane_acc`

## Requirements
- R1: After reset, busy, done, out_valid, pix_ready and acc_ready are all 0.
- R2: A coefficient write while idle with address a = i*K + j sets the tap in kernel row i, column j. A write while busy has no effect, and so does a write to an address of K*K or more.
- R3: The block produces (IMG_W-K+1)*(IMG_H-K+1) results per run, in row-major order. The result for output position (y,x) is clamp(((sum over i,j of img[y+i][x+j]*k[i][j]) >>> s) + p(y,x)), where each product is 18x18 signed and the sum is 48 bits.
- R4: The block consumes exactly one partial-sum value per result, in the same row-major order. acc_ready is never high unless a convolution sum is waiting.
- R5: s is the fraction shift (0..47), sampled at start. The shift is arithmetic and rounds toward minus infinity. The clamp limits the value to the range -131072..131071.
- R6: While out_valid is high and out_ready is low, out_data stays unchanged. With any pattern of stalls on the three streams, no result is lost or repeated.
- R7: With all streams always ready, the done flag is seen IMG_W*IMG_H + 4 clock edges after the start edge. The result for a window appears 3 edges after the edge that accepts its bottom-right pixel.
- R8: pix_ready is 0 while the block is idle and after the last pixel of a run has been accepted. A start pulse while busy is ignored.
- R9: busy falls and done rises on the edge that accepts the last result. done stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | $clog2(K*K) | Coefficient address, row*K + column |
| cfg_coef | input | 18 | Signed coefficient |
| frac_shift | input | 6 | Right shift applied to the convolution sum, sampled at start |
| start | input | 1 | Begins a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last result taken; held until next start |
| pix_valid | input | 1 | Image pixel valid |
| pix_ready | output | 1 | Image pixel accepted when high with pix_valid |
| pix_data | input | 18 | Signed image pixel |
| acc_valid | input | 1 | Partial-sum value valid |
| acc_ready | output | 1 | Partial-sum value accepted when high with acc_valid |
| acc_data | input | 18 | Signed partial-sum value |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with out_valid |
| out_data | output | 18 | Signed saturated result |

## Verification
The bench builds the block with K=3 on a 6 by 5 image, which gives a 4 by 3 output plane. With this size, every output of every run can be checked against sums computed arithmetically in the bench. The bench sweeps a single-tap kernel over all nine coefficient addresses, which covers the tap ordering completely. It runs several shift values from 0 to 47 against signed random data, and drives both saturation limits with extreme operands. Runs with random stalls on all three streams exercise hold and ordering. A run with a write and a start pulse injected while busy confirms that both are ignored, while the cycle count from start to done is also measured.

// File: rtl/conv_acc_pkg.sv
package conv_acc_pkg;
  localparam int DATA_W  = 18;
  localparam int ACC_W   = 48;
  localparam int SHIFT_W = 6;

  typedef logic signed [DATA_W-1:0]   sample_t;
  typedef logic signed [2*DATA_W-1:0] prod_t;
  typedef logic signed [ACC_W-1:0]    acc_t;

  localparam longint SAT_HI = (64'sd1 <<< (DATA_W-1)) - 64'sd1;
  localparam longint SAT_LO = -(64'sd1 <<< (DATA_W-1));

  // Full-precision signed product of one tap.
  function automatic prod_t tap_product(input sample_t a, input sample_t b);
    prod_t pa, pb;
    pa = prod_t'(a);
    pb = prod_t'(b);
    return pa * pb;
  endfunction

  // Clamp a wide signed value into the output sample range.
  function automatic sample_t clamp_sample(input logic signed [ACC_W:0] v);
    if (v > SAT_HI) return sample_t'(SAT_HI);
    if (v < SAT_LO) return sample_t'(SAT_LO);
    return sample_t'(v);
  endfunction

  // Scale the convolution sum, add the partial sum, saturate.
  function automatic sample_t finish_value(input acc_t conv, input sample_t part,
                                           input logic [SHIFT_W-1:0] sh);
    logic signed [ACC_W:0] t;
    t = (ACC_W+1)'(conv);
    t = t >>> sh;
    t = t + (ACC_W+1)'(part);
    return clamp_sample(t);
  endfunction
endpackage

// File: rtl/cpa_coef_bank.sv
module cpa_coef_bank
  import conv_acc_pkg::*;
#(
  parameter int TAPS = 9,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lock,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic signed [DATA_W-1:0] wr_data,
  output logic [TAPS*DATA_W-1:0]   coef_flat
);
  sample_t coef_q [TAPS];

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) coef_q[t] <= '0;
      else if (wr_en && !lock && wr_addr == ADDR_W'(t)) coef_q[t] <= wr_data;
    end
    assign coef_flat[t*DATA_W +: DATA_W] = coef_q[t];
  end

  AST_COEF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(coef_flat)); // R2
endmodule

// File: rtl/cpa_window.sv
module cpa_window
  import conv_acc_pkg::*;
#(
  parameter int K = 3,
  parameter int IMG_W = 32,
  parameter int COL_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [COL_W-1:0]         col,
  input  logic signed [DATA_W-1:0] pix,
  output logic [K*K*DATA_W-1:0]    win_flat
);
  localparam int LINES = K - 1;

  sample_t line_q [LINES][IMG_W];
  sample_t win_q  [K][K];
  sample_t fresh  [K];

  // Newest column: bottom row from the stream, upper rows from the line stores.
  always_comb begin
    fresh[K-1] = pix;
    for (int i = 0; i < K-1; i++) fresh[i] = line_q[K-2-i][col];
  end

  // Line store chain: store m holds the row m+1 above the incoming one.
  always_ff @(posedge clk) begin
    if (push) begin
      line_q[0][col] <= pix;
      for (int m = 1; m < LINES; m++) line_q[m][col] <= line_q[m-1][col];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < K; i++)
        for (int j = 0; j < K; j++) win_q[i][j] <= '0;
    end else if (push) begin
      for (int i = 0; i < K; i++) begin
        for (int j = 0; j < K-1; j++) win_q[i][j] <= win_q[i][j+1];
        win_q[i][K-1] <= fresh[i];
      end
    end
  end

  for (genvar i = 0; i < K; i++) begin : g_row
    for (genvar j = 0; j < K; j++) begin : g_col
      assign win_flat[(i*K+j)*DATA_W +: DATA_W] = win_q[i][j];
    end
  end

  AST_WIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(win_flat)); // R6
endmodule

// File: rtl/cpa_mac.sv
module cpa_mac
  import conv_acc_pkg::*;
#(
  parameter int K = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    in_valid,
  input  logic [K*K*DATA_W-1:0]   win_flat,
  input  logic [K*K*DATA_W-1:0]   coef_flat,
  output logic                    sum_valid,
  output logic signed [ACC_W-1:0] sum
);
  localparam int TAPS = K * K;

  prod_t prod_q [TAPS];
  logic  prod_v;
  acc_t  total;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_v <= 1'b0;
      for (int t = 0; t < TAPS; t++) prod_q[t] <= '0;
    end else if (adv) begin
      prod_v <= in_valid;
      for (int t = 0; t < TAPS; t++)
        prod_q[t] <= tap_product(sample_t'(win_flat[t*DATA_W +: DATA_W]),
                                 sample_t'(coef_flat[t*DATA_W +: DATA_W]));
    end
  end

  always_comb begin
    total = '0;
    for (int t = 0; t < TAPS; t++) total = total + acc_t'(prod_q[t]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_valid <= 1'b0;
      sum       <= '0;
    end else if (adv) begin
      sum_valid <= prod_v;
      sum       <= total;
    end
  end

  AST_SUM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(sum) && $stable(sum_valid)); // R6
endmodule

// File: rtl/cpa_out_stage.sv
module cpa_out_stage
  import conv_acc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sum_valid,
  input  logic signed [ACC_W-1:0]  sum,
  input  logic [SHIFT_W-1:0]       shift,
  input  logic                     acc_valid,
  input  logic signed [DATA_W-1:0] acc_data,
  output logic                     acc_ready,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     adv
);
  logic slot_free, take;

  assign slot_free = !out_valid || out_ready;
  assign acc_ready = sum_valid && slot_free;
  assign take      = acc_ready && acc_valid;
  assign adv       = slot_free && (!sum_valid || acc_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (slot_free) begin
      out_valid <= take;
      if (take) out_data <= finish_value(sum, acc_data, shift);
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6
  AST_PART_MAKES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R4
  AST_SAT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    take && !sum[ACC_W-1] && !acc_data[DATA_W-1] |=> !out_data[DATA_W-1]); // R5
endmodule

// File: rtl/conv_plane_acc.sv
module conv_plane_acc
  import conv_acc_pkg::*;
#(
  parameter int K = 3,
  parameter int IMG_W = 32,
  parameter int IMG_H = 24,
  localparam int TAPS  = K * K,
  localparam int CFG_AW = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic signed [DATA_W-1:0] cfg_coef,
  input  logic [SHIFT_W-1:0]       frac_shift,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  input  logic                     pix_valid,
  output logic                     pix_ready,
  input  logic signed [DATA_W-1:0] pix_data,
  input  logic                     acc_valid,
  output logic                     acc_ready,
  input  logic signed [DATA_W-1:0] acc_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int OUT_W = IMG_W - K + 1;
  localparam int OUT_H = IMG_H - K + 1;
  localparam int NOUT  = OUT_W * OUT_H;
  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);
  localparam int CNT_W = $clog2(NOUT + 1);

  logic               busy_q, done_q, all_in_q, win_v;
  logic [COL_W-1:0]   col_q;
  logic [ROW_W-1:0]   row_q;
  logic [CNT_W-1:0]   out_cnt_q;
  logic [SHIFT_W-1:0] shift_q;

  logic push, win_ok, last_pix, out_fire, adv, sum_valid, start_ok;
  acc_t sum;
  logic [TAPS*DATA_W-1:0] coef_flat, win_flat;

  assign pix_ready = busy_q && !all_in_q && adv;
  assign push      = pix_valid && pix_ready;
  assign win_ok    = (row_q >= ROW_W'(K-1)) && (col_q >= COL_W'(K-1));
  assign last_pix  = (row_q == ROW_W'(IMG_H-1)) && (col_q == COL_W'(IMG_W-1));
  assign out_fire  = out_valid && out_ready;
  assign start_ok  = start && !busy_q;
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      all_in_q  <= 1'b0;
      col_q     <= '0;
      row_q     <= '0;
      out_cnt_q <= '0;
      shift_q   <= '0;
    end else begin
      if (start_ok) begin
        busy_q    <= 1'b1;
        done_q    <= 1'b0;
        all_in_q  <= 1'b0;
        col_q     <= '0;
        row_q     <= '0;
        out_cnt_q <= '0;
        shift_q   <= frac_shift;
      end
      if (push) begin
        if (last_pix) all_in_q <= 1'b1;
        if (col_q == COL_W'(IMG_W-1)) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
      if (out_fire) begin
        out_cnt_q <= out_cnt_q + 1'b1;
        if (out_cnt_q == CNT_W'(NOUT-1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) win_v <= 1'b0;
    else if (adv) win_v <= push && win_ok;
  end

  cpa_coef_bank #(.TAPS(TAPS), .ADDR_W(CFG_AW)) u_coef (
    .clk(clk), .rst_n(rst_n), .lock(busy_q), .wr_en(cfg_we),
    .wr_addr(cfg_addr), .wr_data(cfg_coef), .coef_flat(coef_flat)
  );

  cpa_window #(.K(K), .IMG_W(IMG_W), .COL_W(COL_W)) u_win (
    .clk(clk), .rst_n(rst_n), .push(push), .col(col_q),
    .pix(pix_data), .win_flat(win_flat)
  );

  cpa_mac #(.K(K)) u_mac (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(win_v),
    .win_flat(win_flat), .coef_flat(coef_flat),
    .sum_valid(sum_valid), .sum(sum)
  );

  cpa_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .sum_valid(sum_valid), .sum(sum),
    .shift(shift_q), .acc_valid(acc_valid), .acc_data(acc_data),
    .acc_ready(acc_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .adv(adv)
  );

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(out_valid && out_ready)); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !pix_ready && !out_valid && !acc_ready); // R8
  AST_START_KEEPS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start |=> $stable(shift_q)); // R8
endmodule

// File: tb/conv_plane_acc_tb.sv
module conv_plane_acc_tb;
  localparam int K = 3, W = 6, H = 5;
  localparam int OW = W - K + 1, OH = H - K + 1, NO = OW * OH, NP = W * H;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, start = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic signed [17:0] cfg_coef = '0, pix_data = '0, acc_data = '0;
  logic [5:0] frac_shift = '0;
  logic pix_valid = 1'b0, acc_valid = 1'b0, out_ready = 1'b0;
  logic busy, done, pix_ready, acc_ready, out_valid;
  logic signed [17:0] out_data;

  int errors = 0, checks = 0, sh = 0;
  bit reported = 0;
  int img [H][W];
  int kern [K*K];
  int part [NO];

  always #2.5 clk = ~clk;

  conv_plane_acc #(.K(K), .IMG_W(W), .IMG_H(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_coef(cfg_coef), .frac_shift(frac_shift), .start(start),
    .busy(busy), .done(done), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_data(acc_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  function automatic int expect_at(input int oy, input int ox);
    longint s = 0;
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++)
        s += longint'(img[oy+i][ox+j]) * longint'(kern[i*K+j]);
    s = s >>> sh;
    s += part[oy*OW+ox];
    if (s > 131071) s = 131071;
    if (s < -131072) s = -131072;
    return int'(s);
  endfunction

  function automatic int rnd18();
    return int'($urandom_range(262143)) - 131072;
  endfunction

  function automatic bit go(input int stall_pct);
    return $urandom_range(99) >= stall_pct;
  endfunction

  task automatic load_kernel();
    for (int t = 0; t < K*K; t++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(t); cfg_coef = 18'(kern[t]);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input int stall_pct, input bit poke, input bit timed, input string tag);
    int pi = 0, ai = 0, oi = 0, cyc = 0;
    bit finished = 0, held = 0;
    logic signed [17:0] held_data = '0;
    @(negedge clk);
    frac_shift = 6'(sh); start = 1'b1;
    while (cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start = 1'b0; cfg_we = 1'b0;
      if (done) begin finished = 1; break; end
      if (poke && cyc == 8) begin
        start = 1'b1; frac_shift = 6'd9;                   // R8 start while busy
        cfg_we = 1'b1; cfg_addr = 4'd4; cfg_coef = 18'sd777; // R2 write while busy
      end
      pix_valid = (pi < NP) && go(stall_pct);
      pix_data  = (pi < NP) ? 18'(img[pi / W][pi % W]) : '0;
      acc_valid = (ai < NO) && go(stall_pct);
      acc_data  = (ai < NO) ? 18'(part[ai]) : '0;
      out_ready = go(stall_pct);
      #1;
      if (out_valid) begin
        if (held) check(out_data == held_data, {"R6 hold ", tag}, out_data, held_data);
        if (oi >= NO) check(0, {"R6 extra output ", tag}, oi, NO);
        else if (out_ready) begin
          check(out_data == expect_at(oi / OW, oi % OW), {"R3 value ", tag},
                out_data, expect_at(oi / OW, oi % OW));
          oi++;
          held = 0;
        end else begin
          held = 1; held_data = out_data;
        end
      end
      if (pix_valid && pix_ready) pi++;
      if (acc_valid && acc_ready) ai++;
    end
    pix_valid = 1'b0; acc_valid = 1'b0; out_ready = 1'b0;
    check(finished, {"R9 done seen ", tag}, finished, 1);
    check(oi == NO, {"R6 output count ", tag}, oi, NO);
    check(ai == NO, {"R4 partial count ", tag}, ai, NO);
    check(!busy, {"R9 busy low at done ", tag}, busy, 0);
    if (timed) check(cyc == NP + 5, {"R7 start-to-done ", tag}, cyc, NP + 5);
    @(negedge clk);
    pix_valid = 1'b1; out_ready = 1'b1;
    #1;
    check(!pix_ready && !out_valid, {"R8 idle ignores pixels ", tag}, pix_ready, 0);
    check(done, {"R9 done held ", tag}, done, 1);
    @(negedge clk);
    pix_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic fill_random(input int lim);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) img[y][x] = (rnd18() % lim);
    for (int t = 0; t < K*K; t++) kern[t] = (rnd18() % lim);
    for (int o = 0; o < NO; o++) part[o] = (rnd18() % lim);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!busy && !done && !out_valid && !pix_ready && !acc_ready,
          "R1 reset state", {busy, done, out_valid, pix_ready, acc_ready}, 0);

    // R2 tap ordering: one nonzero tap at every address in turn.
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) img[y][x] = 10 * y + x + 1;
    for (int o = 0; o < NO; o++) part[o] = 0;
    for (int a = 0; a < K*K; a++) begin
      for (int t = 0; t < K*K; t++) kern[t] = (t == a) ? 3 : 0;
      sh = 0;
      load_kernel();
      run(0, 0, 1, "R2 tap sweep");
    end

    // R2 out-of-range addresses leave the kernel unchanged.
    fill_random(4000);
    load_kernel();
    for (int a = K*K; a < 16; a++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_coef = 18'sd99999;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    sh = 2;
    run(0, 0, 1, "R2 out-of-range write");

    // R5 shift sweep with signed data.
    foreach (kern[t]) kern[t] = 0;
    for (int s = 0; s < 6; s++) begin
      int shifts [6] = '{0, 1, 3, 7, 20, 47};
      fill_random(131072);
      sh = shifts[s];
      load_kernel();
      run(0, 0, 1, "R5 shift sweep");
    end

    // R5 saturation at both limits.
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = 131071;
    for (int t = 0; t < K*K; t++) kern[t] = 131071;
    for (int o = 0; o < NO; o++) part[o] = 131071;
    sh = 0;
    load_kernel();
    run(0, 0, 0, "R5 positive clamp");
    for (int t = 0; t < K*K; t++) kern[t] = -131072;
    for (int o = 0; o < NO; o++) part[o] = -131072;
    load_kernel();
    run(0, 0, 0, "R5 negative clamp");

    // R6 random stalls on all three streams.
    for (int r = 0; r < 4; r++) begin
      fill_random(20000);
      sh = r * 3;
      load_kernel();
      run(40, 0, 0, "R6 stall run");
    end

    // R2/R8 write and start while busy are ignored; timing unchanged.
    fill_random(50000);
    sh = 4;
    load_kernel();
    run(0, 1, 1, "R8 busy poke");
    run(0, 0, 1, "R2 kernel after busy write");

    summary();
    $finish;
  end
endmodule